// File: doc/BRIEF.md
# Colored Store Buffer with Load Forwarding

This block holds in-flight stores between their allocation in program order and their final write to memory. Every store receives a slot number (its color) when it is allocated. Its address and its data arrive later and separately, from two independent write ports. Every load carries the color of the youngest store allocated before it. When the load executes, the buffer looks only at stores of that color or older. Depending on what it finds, it answers with forwarded data, a block that asks for re-execution, or a miss that sends the load to the cache.

A retire pulse makes the oldest not-yet-retired store senior. Senior stores leave for memory strictly oldest first, one per cycle. They leave only while the memory port reports idle, or while every slot is occupied. A flush discards all speculative (non-senior) stores and keeps the senior ones. The next color handed out is then the slot just past the youngest senior store.

Top module: `store_color_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_rdy`=1, `alloc_id`=0, and `rsp_vld` and `mem_wr_vld` are 0.
- R2: Colors are handed out as slot numbers 0,1,…,11,0,… in allocation order. `alloc_id` shows the color the next accepted store will get. With all 12 slots held, `alloc_rdy` is 0 and an `alloc_vld` pulse is refused, leaving `alloc_id` unchanged.
- R3: A load with `ld_has_older`=0, or one whose window (stores from the oldest up to and including color `ld_color`) holds no store with an unknown address and no overlapping byte range, gets a miss. Stores younger than the tag are ignored.
- R4: If the youngest candidate in the window has the same start address, and the load size code is less than or equal to the store's, and its data was written, the load is forwarded. Size code s means 2^s bytes (0..3). The forwarded data is the store data with all bytes above the load's width forced to zero.
- R5: When several stores in the window qualify, the youngest of them alone decides the answer.
- R6: The load is blocked when the deciding store has an unknown address, overlaps with a different start, is narrower than the load, or has no data yet.
- R7: Every query gets its answer exactly one cycle later on `rsp_vld`, with exactly one of `rsp_fwd`, `rsp_blk` and `rsp_miss` set.
- R8: `ret_vld` makes the oldest non-senior store senior. Senior stores appear on `mem_wr_*` oldest first, one cycle after the cycle in which they drain. A store drains when `mem_idle`=1, or when all 12 slots are held.
- R9: With `mem_idle`=0 and fewer than 12 slots held, senior stores stay in the buffer and keep taking part in load checks.
- R10: On `flush` every non-senior store is freed, senior stores are kept and still drain, and the next `alloc_id` is the slot after the youngest senior store. In a flush cycle `alloc_vld`, `ret_vld`, `aw_vld` and `dw_vld` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Allocate one store |
| alloc_rdy | output | 1 | A free slot exists |
| alloc_id | output | 4 | Color given to the next allocated store |
| aw_vld | input | 1 | Store address write |
| aw_id | input | 4 | Target color for the address write |
| aw_addr | input | 16 | Store start address |
| aw_size | input | 2 | Store size code (2^s bytes) |
| dw_vld | input | 1 | Store data write |
| dw_id | input | 4 | Target color for the data write |
| dw_data | input | 64 | Store data, low bytes first |
| ret_vld | input | 1 | Retire the oldest non-senior store |
| flush | input | 1 | Discard speculative stores |
| ld_vld | input | 1 | Load query |
| ld_has_older | input | 1 | An older store is still in the buffer |
| ld_color | input | 4 | Color of the youngest older store |
| ld_addr | input | 16 | Load start address |
| ld_size | input | 2 | Load size code |
| rsp_vld | output | 1 | Query answer valid |
| rsp_fwd | output | 1 | Data forwarded |
| rsp_blk | output | 1 | Load must re-execute |
| rsp_miss | output | 1 | No conflicting store |
| rsp_data | output | 64 | Forwarded data |
| mem_idle | input | 1 | Memory port idle |
| mem_wr_vld | output | 1 | Memory write |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_size | output | 2 | Memory write size code |
| mem_wr_data | output | 64 | Memory write data |

## Verification
Loads are issued against a full buffer whose entries differ in start address, width, address presence and data presence. The directed cases separate the answers: a tag that sits just below a matching store exposes a window that ignores age, and two stores at one address show whether the youngest decides. A narrower store, a shifted start and a missing address or data each show one blocking cause apart from forwarding. Drain tests hold `mem_idle` low with a full and then a non-full buffer, and flush tests mix senior and speculative entries, so that a wrong drain condition or a wrong rewind point surfaces. A long stretch of mixed traffic on a narrow address range then compares every output with the model on every clock.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    LD_MISS = 2'd0,
    LD_FWD  = 2'd1,
    LD_BLK  = 2'd2
  } ld_answer_e;
endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl #(
  parameter int N_ENT = 12,
  localparam int ID_W = $clog2(N_ENT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_fire,
  input  logic            retire_fire,
  input  logic            drain_fire,
  input  logic            flush,
  output logic [ID_W-1:0] head,
  output logic [ID_W-1:0] tail,
  output logic [ID_W-1:0] sen_ptr
);
  function automatic logic [ID_W-1:0] step(logic [ID_W-1:0] p);
    return (p == ID_W'(N_ENT - 1)) ? '0 : p + 1'b1;
  endfunction

  // head: oldest entry, sen_ptr: oldest non-senior, tail: next free
  always_ff @(posedge clk) begin
    if (rst) begin
      head    <= '0;
      tail    <= '0;
      sen_ptr <= '0;
    end else begin
      if (drain_fire) head <= step(head);
      if (flush) begin
        tail <= sen_ptr;
      end else begin
        if (alloc_fire)  tail    <= step(tail);
        if (retire_fire) sen_ptr <= step(sen_ptr);
      end
    end
  end
endmodule

// File: rtl/sb_fwd_check.sv
module sb_fwd_check
  import sb_pkg::*;
#(
  parameter int N_ENT  = 12,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int SZ_W   = 2,
  localparam int ID_W  = $clog2(N_ENT),
  localparam int NBYTE = DATA_W / 8
) (
  input  logic [ID_W-1:0]   head,
  input  logic [N_ENT-1:0]  ent_v,
  input  logic [N_ENT-1:0]  ent_av,
  input  logic [N_ENT-1:0]  ent_dv,
  input  logic [ADDR_W-1:0] ent_addr [N_ENT],
  input  logic [SZ_W-1:0]   ent_size [N_ENT],
  input  logic [DATA_W-1:0] ent_data [N_ENT],
  input  logic              q_older,
  input  logic [ID_W-1:0]   q_color,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [SZ_W-1:0]   q_size,
  output ld_answer_e        answer,
  output logic [DATA_W-1:0] fwd_data
);
  function automatic int wrap_add(int a, int b);
    int r;
    r = a + b;
    return (r >= N_ENT) ? r - N_ENT : r;
  endfunction

  function automatic logic overlaps(logic [ADDR_W-1:0] a, logic [SZ_W-1:0] sa,
                                    logic [ADDR_W-1:0] b, logic [SZ_W-1:0] sb);
    logic [ADDR_W:0] a_lo, a_hi, b_lo, b_hi;
    a_lo = {1'b0, a};
    b_lo = {1'b0, b};
    a_hi = a_lo + ((ADDR_W+1)'(1) << sa);
    b_hi = b_lo + ((ADDR_W+1)'(1) << sb);
    return (a_lo < b_hi) && (b_lo < a_hi);
  endfunction

  int   tag_dist;
  int   sel;
  logic found;

  // Walk the window oldest to youngest; the last candidate seen wins.
  always_comb begin
    tag_dist = (int'(q_color) >= int'(head)) ? int'(q_color) - int'(head)
                                             : int'(q_color) + N_ENT - int'(head);
    found = 1'b0;
    sel   = 0;
    for (int k = 0; k < N_ENT; k++) begin
      if (q_older && k <= tag_dist && ent_v[wrap_add(int'(head), k)] &&
          (!ent_av[wrap_add(int'(head), k)] ||
           overlaps(ent_addr[wrap_add(int'(head), k)], ent_size[wrap_add(int'(head), k)],
                    q_addr, q_size))) begin
        found = 1'b1;
        sel   = wrap_add(int'(head), k);
      end
    end
    answer = LD_MISS;
    if (found) begin
      if (ent_av[sel] && ent_dv[sel] && ent_addr[sel] == q_addr && q_size <= ent_size[sel])
        answer = LD_FWD;
      else
        answer = LD_BLK;
    end
  end

  always_comb begin
    for (int b = 0; b < NBYTE; b++) begin
      fwd_data[b*8 +: 8] = (answer == LD_FWD && b < (1 << int'(q_size)))
                         ? ent_data[sel][b*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/sb_mem_port.sv
module sb_mem_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int SZ_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drain_fire,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [SZ_W-1:0]   d_size,
  input  logic [DATA_W-1:0] d_data,
  output logic              mem_wr_vld,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [SZ_W-1:0]   mem_wr_size,
  output logic [DATA_W-1:0] mem_wr_data
);
  always_ff @(posedge clk) begin
    if (rst) mem_wr_vld <= 1'b0;
    else     mem_wr_vld <= drain_fire;
  end

  always_ff @(posedge clk) begin
    if (drain_fire) begin
      mem_wr_addr <= d_addr;
      mem_wr_size <= d_size;
      mem_wr_data <= d_data;
    end
  end
endmodule

// File: rtl/store_color_buf.sv
module store_color_buf
  import sb_pkg::*;
#(
  parameter int N_ENT  = 12,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int SZ_W   = 2,
  localparam int ID_W  = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_vld,
  output logic              alloc_rdy,
  output logic [ID_W-1:0]   alloc_id,
  input  logic              aw_vld,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [SZ_W-1:0]   aw_size,
  input  logic              dw_vld,
  input  logic [ID_W-1:0]   dw_id,
  input  logic [DATA_W-1:0] dw_data,
  input  logic              ret_vld,
  input  logic              flush,
  input  logic              ld_vld,
  input  logic              ld_has_older,
  input  logic [ID_W-1:0]   ld_color,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SZ_W-1:0]   ld_size,
  output logic              rsp_vld,
  output logic              rsp_fwd,
  output logic              rsp_blk,
  output logic              rsp_miss,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              mem_idle,
  output logic              mem_wr_vld,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [SZ_W-1:0]   mem_wr_size,
  output logic [DATA_W-1:0] mem_wr_data
);
  logic [N_ENT-1:0]  ent_v, ent_av, ent_dv, ent_sen;
  logic [ADDR_W-1:0] ent_addr [N_ENT];
  logic [SZ_W-1:0]   ent_size [N_ENT];
  logic [DATA_W-1:0] ent_data [N_ENT];

  logic [ID_W-1:0] head, tail, sen_ptr;
  logic alloc_fire, retire_fire, drain_fire, aw_fire, dw_fire, buf_full;
  ld_answer_e        answer;
  logic [DATA_W-1:0] fwd_data;

  assign buf_full    = &ent_v;
  assign alloc_rdy   = !ent_v[tail];
  assign alloc_id    = tail;
  assign alloc_fire  = alloc_vld && alloc_rdy && !flush;
  assign retire_fire = ret_vld && !flush && ent_v[sen_ptr] && !ent_sen[sen_ptr];
  assign drain_fire  = ent_v[head] && ent_sen[head] && (mem_idle || buf_full);
  assign aw_fire     = aw_vld && !flush && (int'(aw_id) < N_ENT) && ent_v[aw_id];
  assign dw_fire     = dw_vld && !flush && (int'(dw_id) < N_ENT) && ent_v[dw_id];

  sb_ptr_ctrl #(.N_ENT(N_ENT)) u_ptr (
    .clk         (clk),
    .rst         (rst),
    .alloc_fire  (alloc_fire),
    .retire_fire (retire_fire),
    .drain_fire  (drain_fire),
    .flush       (flush),
    .head        (head),
    .tail        (tail),
    .sen_ptr     (sen_ptr)
  );

  // Per-entry state flags
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v   <= '0;
      ent_av  <= '0;
      ent_dv  <= '0;
      ent_sen <= '0;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (drain_fire && head == ID_W'(i)) begin
          ent_v[i]   <= 1'b0;
          ent_sen[i] <= 1'b0;
        end
        if (flush) begin
          if (!ent_sen[i]) ent_v[i] <= 1'b0;
        end else begin
          if (alloc_fire && tail == ID_W'(i)) begin
            ent_v[i]   <= 1'b1;
            ent_av[i]  <= 1'b0;
            ent_dv[i]  <= 1'b0;
            ent_sen[i] <= 1'b0;
          end
          if (aw_fire && aw_id == ID_W'(i))       ent_av[i]  <= 1'b1;
          if (dw_fire && dw_id == ID_W'(i))       ent_dv[i]  <= 1'b1;
          if (retire_fire && sen_ptr == ID_W'(i)) ent_sen[i] <= 1'b1;
        end
      end
    end
  end

  // Payload storage: single write port each, no reset
  always_ff @(posedge clk) begin
    if (aw_fire) begin
      ent_addr[aw_id] <= aw_addr;
      ent_size[aw_id] <= aw_size;
    end
  end

  always_ff @(posedge clk) begin
    if (dw_fire) ent_data[dw_id] <= dw_data;
  end

  sb_fwd_check #(
    .N_ENT (N_ENT),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SZ_W  (SZ_W)
  ) u_fwd (
    .head     (head),
    .ent_v    (ent_v),
    .ent_av   (ent_av),
    .ent_dv   (ent_dv),
    .ent_addr (ent_addr),
    .ent_size (ent_size),
    .ent_data (ent_data),
    .q_older  (ld_has_older),
    .q_color  (ld_color),
    .q_addr   (ld_addr),
    .q_size   (ld_size),
    .answer   (answer),
    .fwd_data (fwd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld  <= 1'b0;
      rsp_fwd  <= 1'b0;
      rsp_blk  <= 1'b0;
      rsp_miss <= 1'b0;
    end else begin
      rsp_vld  <= ld_vld;
      rsp_fwd  <= ld_vld && answer == LD_FWD;
      rsp_blk  <= ld_vld && answer == LD_BLK;
      rsp_miss <= ld_vld && answer == LD_MISS;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_vld) rsp_data <= fwd_data;
  end

  sb_mem_port #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SZ_W  (SZ_W)
  ) u_mem (
    .clk         (clk),
    .rst         (rst),
    .drain_fire  (drain_fire),
    .d_addr      (ent_addr[head]),
    .d_size      (ent_size[head]),
    .d_data      (ent_data[head]),
    .mem_wr_vld  (mem_wr_vld),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_size (mem_wr_size),
    .mem_wr_data (mem_wr_data)
  );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int N_ENT = 12,
  localparam int ID_W = $clog2(N_ENT)
) (
  input logic            clk,
  input logic            rst,
  input logic            alloc_vld,
  input logic            alloc_rdy,
  input logic [ID_W-1:0] alloc_id,
  input logic            flush,
  input logic            ld_vld,
  input logic            rsp_vld,
  input logic            rsp_fwd,
  input logic            rsp_blk,
  input logic            rsp_miss,
  input logic            mem_idle,
  input logic            mem_wr_vld
);
  // R1: empty state right after reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (alloc_rdy && alloc_id == '0 && !rsp_vld && !mem_wr_vld));

  // R2: accepted allocation moves the color by one, wrapping at N_ENT
  p_color_step_r2: assert property (@(posedge clk) disable iff (rst)
    (alloc_vld && alloc_rdy && !flush) |=>
      alloc_id == (($past(alloc_id) == ID_W'(N_ENT - 1)) ? '0 : $past(alloc_id) + 1'b1));

  // R7: one-cycle answer latency
  p_rsp_latency_r7: assert property (@(posedge clk) disable iff (rst)
    ld_vld |=> rsp_vld);

  // R7: exactly one answer kind
  p_rsp_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> $countones({rsp_fwd, rsp_blk, rsp_miss}) == 1);

  // R7: no answer without a query
  p_rsp_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !rsp_vld |-> !(rsp_fwd || rsp_blk || rsp_miss));

  // R8/R9: a write while memory was busy needs a full buffer
  p_drain_cond_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_vld && !$past(mem_idle)) |-> !$past(alloc_rdy));
endmodule

bind store_color_buf sb_checker #(.N_ENT(N_ENT)) u_sb_checker (
  .clk        (clk),
  .rst        (rst),
  .alloc_vld  (alloc_vld),
  .alloc_rdy  (alloc_rdy),
  .alloc_id   (alloc_id),
  .flush      (flush),
  .ld_vld     (ld_vld),
  .rsp_vld    (rsp_vld),
  .rsp_fwd    (rsp_fwd),
  .rsp_blk    (rsp_blk),
  .rsp_miss   (rsp_miss),
  .mem_idle   (mem_idle),
  .mem_wr_vld (mem_wr_vld)
);

// File: tb/tb_store_color_buf.sv
`timescale 1ns/1ps
module tb_store_color_buf;
  localparam int N = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, alloc_vld, aw_vld, dw_vld, ret_vld, flush, ld_vld, ld_has_older, mem_idle;
  logic [3:0]  aw_id, dw_id, ld_color;
  logic [15:0] aw_addr, ld_addr;
  logic [1:0]  aw_size, ld_size;
  logic [63:0] dw_data;
  logic alloc_rdy, rsp_vld, rsp_fwd, rsp_blk, rsp_miss, mem_wr_vld;
  logic [3:0]  alloc_id;
  logic [63:0] rsp_data, mem_wr_data;
  logic [15:0] mem_wr_addr;
  logic [1:0]  mem_wr_size;

  store_color_buf dut (
    .clk(clk), .rst(rst), .alloc_vld(alloc_vld), .alloc_rdy(alloc_rdy), .alloc_id(alloc_id),
    .aw_vld(aw_vld), .aw_id(aw_id), .aw_addr(aw_addr), .aw_size(aw_size),
    .dw_vld(dw_vld), .dw_id(dw_id), .dw_data(dw_data), .ret_vld(ret_vld), .flush(flush),
    .ld_vld(ld_vld), .ld_has_older(ld_has_older), .ld_color(ld_color), .ld_addr(ld_addr),
    .ld_size(ld_size), .rsp_vld(rsp_vld), .rsp_fwd(rsp_fwd), .rsp_blk(rsp_blk),
    .rsp_miss(rsp_miss), .rsp_data(rsp_data), .mem_idle(mem_idle), .mem_wr_vld(mem_wr_vld),
    .mem_wr_addr(mem_wr_addr), .mem_wr_size(mem_wr_size), .mem_wr_data(mem_wr_data)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  // ---------------- reference model ----------------
  int q[$];
  int m_addr[N];
  int m_size[N];
  logic [63:0] m_data[N];
  bit m_av[N], m_dv[N], m_sen[N];
  int nid;
  bit e_rsp_vld, e_fwd, e_blk, e_miss, e_mem_vld;
  logic [63:0] e_rsp_data, e_mem_data;
  int e_mem_addr, e_mem_size;
  int pos, tid, decided, pre_size, nsen, lo_a, hi_a, lo_b, hi_b;
  bit dr;

  function automatic logic [63:0] mask_of(int s);
    return (s == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ((1 << s) * 8)) - 64'd1);
  endfunction

  function automatic bit in_q(int id);
    foreach (q[i]) if (q[i] == id) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      nid = 0;
      e_rsp_vld = 0; e_fwd = 0; e_blk = 0; e_miss = 0; e_mem_vld = 0;
    end else begin
      // load answer from state before the edge
      e_rsp_vld = ld_vld; e_fwd = 0; e_blk = 0; e_miss = 0;
      if (ld_vld) begin
        pos = -1;
        if (ld_has_older) foreach (q[i]) if (q[i] == int'(ld_color)) pos = i;
        decided = 0;
        for (int k = pos; k >= 0; k--) begin
          if (decided == 0) begin
            tid = q[k];
            lo_a = m_addr[tid]; hi_a = lo_a + (1 << m_size[tid]);
            lo_b = int'(ld_addr); hi_b = lo_b + (1 << int'(ld_size));
            if (!m_av[tid]) begin
              e_blk = 1; decided = 1;
            end else if (lo_a < hi_b && lo_b < hi_a) begin
              decided = 1;
              if (lo_a == lo_b && int'(ld_size) <= m_size[tid] && m_dv[tid]) begin
                e_fwd = 1; e_rsp_data = m_data[tid] & mask_of(int'(ld_size));
              end else e_blk = 1;
            end
          end
        end
        if (decided == 0) e_miss = 1;
      end
      // drain decision
      pre_size = q.size();
      dr = (pre_size > 0) && m_sen[q[0]] && (mem_idle || pre_size == N);
      e_mem_vld = dr;
      if (dr) begin
        e_mem_addr = m_addr[q[0]]; e_mem_size = m_size[q[0]]; e_mem_data = m_data[q[0]];
      end
      if (flush) begin
        if (pre_size > 0) begin
          nsen = 0;
          foreach (q[i]) if (m_sen[q[i]]) nsen++;
          nid = (q[0] + nsen) % N;
        end
        if (dr) void'(q.pop_front());
        while (q.size() > 0 && !m_sen[q[q.size()-1]]) void'(q.pop_back());
      end else begin
        if (ret_vld) begin
          decided = 0;
          foreach (q[i]) if (decided == 0 && !m_sen[q[i]]) begin m_sen[q[i]] = 1; decided = 1; end
        end
        if (aw_vld && in_q(int'(aw_id))) begin
          m_av[aw_id] = 1; m_addr[aw_id] = int'(aw_addr); m_size[aw_id] = int'(aw_size);
        end
        if (dw_vld && in_q(int'(dw_id))) begin
          m_dv[dw_id] = 1; m_data[dw_id] = dw_data;
        end
        if (dr) void'(q.pop_front());
        if (alloc_vld && pre_size < N) begin
          q.push_back(nid);
          m_av[nid] = 0; m_dv[nid] = 0; m_sen[nid] = 0;
          nid = (nid + 1) % N;
        end
      end
    end
  end

  // ---------------- comparison ----------------
  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s phase=%s act=%h exp=%h t=%0t", req, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(alloc_rdy == (q.size() < N), "R2 alloc_rdy", 64'(alloc_rdy), 64'(q.size() < N));
      check(int'(alloc_id) == nid, "R2 R10 alloc_id", 64'(alloc_id), 64'(nid));
      check(rsp_vld == e_rsp_vld && rsp_fwd == e_fwd && rsp_blk == e_blk && rsp_miss == e_miss,
            "R7 R3 R4 R5 R6 answer", {60'd0, rsp_vld, rsp_fwd, rsp_blk, rsp_miss},
            {60'd0, e_rsp_vld, e_fwd, e_blk, e_miss});
      if (e_fwd) check(rsp_data == e_rsp_data, "R4 R5 rsp_data", rsp_data, e_rsp_data);
      check(mem_wr_vld == e_mem_vld, "R8 R9 mem_wr_vld", 64'(mem_wr_vld), 64'(e_mem_vld));
      if (e_mem_vld) begin
        check(int'(mem_wr_addr) == e_mem_addr && int'(mem_wr_size) == e_mem_size,
              "R8 mem_wr_addr/size", {46'd0, mem_wr_size, mem_wr_addr},
              {46'd0, 2'(e_mem_size), 16'(e_mem_addr)});
        check(mem_wr_data == e_mem_data, "R8 mem_wr_data", mem_wr_data, e_mem_data);
      end
    end
  end

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog phase=%s act=%h exp=%h", phase, 64'(cycles), 64'd20000);
      report();
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_alloc();
    alloc_vld = 1; tick(); alloc_vld = 0;
  endtask

  task automatic do_aw(int id, int a, int s);
    aw_vld = 1; aw_id = 4'(id); aw_addr = 16'(a); aw_size = 2'(s); tick(); aw_vld = 0;
  endtask

  task automatic do_dw(int id, logic [63:0] d);
    dw_vld = 1; dw_id = 4'(id); dw_data = d; tick(); dw_vld = 0;
  endtask

  task automatic do_load(bit older, int color, int a, int s);
    ld_vld = 1; ld_has_older = older; ld_color = 4'(color); ld_addr = 16'(a); ld_size = 2'(s);
    tick(); ld_vld = 0;
  endtask

  task automatic do_retire();
    ret_vld = 1; tick(); ret_vld = 0;
  endtask

  initial begin
    rst = 1; alloc_vld = 0; aw_vld = 0; dw_vld = 0; ret_vld = 0; flush = 0; ld_vld = 0;
    ld_has_older = 0; mem_idle = 0; aw_id = 0; dw_id = 0; ld_color = 0; aw_addr = 0;
    ld_addr = 0; aw_size = 0; ld_size = 0; dw_data = 0;
    repeat (3) tick();
    rst = 0;
    // R1: reset state observed by the per-cycle compare
    phase = "R1"; tick(); tick();

    // R2: fill all slots, then try one more
    phase = "R2";
    for (int i = 0; i < N; i++) do_alloc();
    do_alloc(); do_alloc();
    for (int i = 0; i < N; i++) begin
      if (i == 2) do_aw(i, 16'h200, 2);
      else if (i == 5) do_aw(i, 16'h200, 3);
      else if (i != 7) do_aw(i, 16'h100 + 16 * i, 3);
      if (i != 8) do_dw(i, 64'h1111_2222_3333_4400 + 64'(i));
    end

    // R3: misses, including a matching store younger than the tag
    phase = "R3";
    do_load(0, 0, 16'h200, 2);
    do_load(1, 1, 16'h200, 2);
    do_load(1, 6, 16'h800, 3);
    // R4: forwarding with narrower loads
    phase = "R4";
    do_load(1, 2, 16'h200, 1);
    do_load(1, 4, 16'h200, 2);
    // R5: youngest of two matches supplies
    phase = "R5";
    do_load(1, 6, 16'h200, 3);
    // R6: blocking causes
    phase = "R6";
    do_load(1, 4, 16'h200, 3);
    do_load(1, 6, 16'h202, 0);
    do_load(1, 7, 16'h900, 1);
    do_load(1, 8, 16'h180, 3);
    do_load(1, 3, 16'h134, 0);
    do_aw(7, 16'h170, 3);
    phase = "R4";
    do_load(1, 7, 16'h170, 2);
    do_dw(8, 64'hDEAD_BEEF_0000_0008);

    // R8: full buffer drains with memory busy; R9: then waits
    phase = "R8";
    mem_idle = 0;
    do_retire(); do_retire(); do_retire();
    phase = "R9";
    repeat (4) tick();
    do_load(1, 2, 16'h200, 2);
    phase = "R8";
    mem_idle = 1; repeat (3) tick(); mem_idle = 0;

    // R10: flush keeps seniors and rewinds allocation
    phase = "R10";
    do_retire(); do_retire();
    flush = 1; alloc_vld = 1; ret_vld = 1; tick(); flush = 0; alloc_vld = 0; ret_vld = 0;
    tick();
    do_alloc(); do_alloc();
    do_load(1, 6, 16'h200, 0);
    mem_idle = 1; repeat (3) tick(); mem_idle = 0;
    flush = 1; tick(); flush = 0; tick();

    // mixed traffic on a narrow address range
    phase = "R3 R4 R5 R6 R8 R10 mix";
    for (int c = 0; c < 600; c++) begin
      alloc_vld = ($urandom % 3) == 0;
      ret_vld   = ($urandom % 4) == 0;
      flush     = ($urandom % 50) == 0;
      mem_idle  = ($urandom % 3) == 0;
      aw_vld = 0; dw_vld = 0; ld_vld = 0;
      if (q.size() > 0) begin
        tid = q[$urandom % q.size()];
        if (!m_sen[tid] && ($urandom % 2) == 0) begin
          aw_vld = 1; aw_id = 4'(tid);
          aw_addr = 16'(16'h100 + ($urandom % 6) * 2); aw_size = 2'($urandom % 4);
        end
        tid = q[$urandom % q.size()];
        if (!m_sen[tid] && ($urandom % 2) == 0) begin
          dw_vld = 1; dw_id = 4'(tid); dw_data = {$urandom, $urandom};
        end
      end
      if (($urandom % 2) == 0) begin
        ld_vld = 1;
        ld_has_older = (q.size() > 0) && (($urandom % 5) != 0);
        ld_color = (q.size() > 0) ? 4'(q[$urandom % q.size()]) : 4'd0;
        ld_addr = 16'(16'h100 + ($urandom % 6) * 2); ld_size = 2'($urandom % 4);
      end
      tick();
    end
    alloc_vld = 0; ret_vld = 0; flush = 0; aw_vld = 0; dw_vld = 0; ld_vld = 0; mem_idle = 1;
    repeat (20) tick();
    report();
  end
endmodule